// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO Slice

This block is one slice of a deep FIFO built from several identical small FIFOs joined in a ring. All slices share the write and read buses. Ownership of writing and ownership of reading each move from slice to slice as a token. One serial cascade line runs from each slice to the next, and the line from the last slice returns to the first. No logic sits between the slices. A strap input marks the head slice. The head slice comes out of reset with both tokens, and every other slice comes out with neither.

The slice that owns the write token stores words until it is full. It then sends a short high pulse to the next slice and gives up the token. The slice that owns the read token presents its oldest word and pops on a read. Once it has read out the last word of a block it filled earlier, it sends a longer high pulse that hands the read token on. The receiver tells the two kinds apart by pulse length. A slice that gets the write token back while it still holds unread words from its previous lap accepts nothing until that block is gone. This keeps the whole ring in strict arrival order.

Top module: `casc_fifo_slice`

## Requirements
- R1: After reset the slice with `strap_head_n` low has `wr_ok` high, and every other slice has `wr_ok` low. In all slices `rd_vld` and `casc_o` are low.
- R2: A word is stored only on a clock edge where `wr_en` and `wr_ok` are both high. A slice with `wr_ok` low ignores `wr_en`. At most one slice in a ring has `wr_ok` high at any time.
- R3: The write that brings the write-token owner to DEPTH words clears its `wr_ok` after that edge. It also drives `casc_o` high for exactly one cycle, starting right after that edge.
- R4: A read that pops the last word of a block the slice filled earlier clears its `rd_vld` after that edge. It also drives `casc_o` high for exactly two consecutive cycles, and `casc_o` then returns low.
- R5: A receiver gains the write token on the edge where `casc_i` is sampled low after exactly one high sample. `wr_ok` of the receiver rises after that edge, which is two edges after the sender's filling write.
- R6: A receiver gains the read token on the edge where `casc_i` is sampled low after exactly two high samples. `rd_vld` rises after that edge if the slice holds data, which is three edges after the sender's draining read.
- R7: A slice that receives the write token while it still holds unread words of its earlier block keeps `wr_ok` low, even when it has free room. `wr_ok` rises on the edge that pops the last of those words.
- R8: A slice that owns both tokens and reads itself empty keeps the read token. It sends nothing on `casc_o`, and its `rd_vld` rises again once a new word is written.
- R9: `rd_data` shows the slice's oldest word while `rd_vld` is high (show-ahead), and reads as zero while `rd_vld` is low.
- R10: Across the ring, the words read out equal the words accepted, in the same order.
- R11: A simultaneous read and write on a slice that owns both tokens and holds one word pops the old word and leaves the new word at the head. `wr_ok` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the ring |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_head_n | input | 1 | Low on the one head slice, high on all others |
| wr_en | input | 1 | Write request, shared by all slices |
| wr_data | input | WIDTH | Write word, shared by all slices |
| wr_ok | output | 1 | This slice stores a word on the next edge if `wr_en` is high |
| rd_en | input | 1 | Read request, shared by all slices |
| rd_vld | output | 1 | This slice owns the read token and holds data |
| rd_data | output | WIDTH | Oldest word of this slice, zero when not valid |
| casc_i | input | 1 | Token line from the previous slice |
| casc_o | output | 1 | Token line to the next slice |

## Verification
The bench builds a ring of three slices with DEPTH 4 and WIDTH 8. With so few words per slice, a handful of writes hands a token over. Twelve words wrap the write token back onto a slice that still holds its unread block, so the stale-block stall is reached. Directed scenarios check the exact edges of both pulse kinds and of both token takeovers. A long mixed phase, with free-running read and write requests, laps the ring many times while the order of every word is checked.

// File: rtl/casc_fifo_pkg.sv
`timescale 1ns/1ps
package casc_fifo_pkg;

   // High-time of each token pulse on the cascade line, in cycles
   localparam int unsigned CASC_WR_HI     = 1;
   localparam int unsigned CASC_RD_HI     = 2;
   // Pulses from one slice must be separated by a low cycle
   localparam int unsigned CASC_MIN_DEPTH = CASC_RD_HI + 1;
   localparam int unsigned CASC_RUN_W     = 2;

   typedef enum logic [1:0] {
      TOK_NONE = 2'd0,
      TOK_WR   = 2'd1,
      TOK_RD   = 2'd2
   } casc_tok_e;

endpackage

// File: rtl/casc_link_tx.sv
`timescale 1ns/1ps
module casc_link_tx
   import casc_fifo_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  casc_tok_e send,
   output logic      casc_o
);

   localparam logic [CASC_RUN_W-1:0] WR_HOLD = CASC_RUN_W'(CASC_WR_HI - 1);
   localparam logic [CASC_RUN_W-1:0] RD_HOLD = CASC_RUN_W'(CASC_RD_HI - 1);

   logic [CASC_RUN_W-1:0] hold_q;
   logic                  line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         line_q <= 1'b0;
      end else if (send == TOK_WR) begin
         hold_q <= WR_HOLD;
         line_q <= 1'b1;
      end else if (send == TOK_RD) begin
         hold_q <= RD_HOLD;
         line_q <= 1'b1;
      end else if (hold_q != '0) begin
         hold_q <= hold_q - 1'b1;
         line_q <= 1'b1;
      end else begin
         line_q <= 1'b0;
      end
   end

   assign casc_o = line_q;

   p_tx_idle_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (send != TOK_NONE) |-> !casc_o);
   p_wr_pulse_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (send == TOK_WR) |=> casc_o ##1 !casc_o);
   p_rd_pulse_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (send == TOK_RD) |=> casc_o ##1 casc_o ##1 !casc_o);

endmodule

// File: rtl/casc_link_rx.sv
`timescale 1ns/1ps
module casc_link_rx
   import casc_fifo_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      casc_i,
   output casc_tok_e gain
);

   logic [CASC_RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (casc_i)
         run_q <= (run_q == '1) ? run_q : run_q + 1'b1;
      else
         run_q <= '0;
   end

   always_comb begin
      gain = TOK_NONE;
      if (!casc_i && run_q == CASC_RUN_W'(CASC_WR_HI)) gain = TOK_WR;
      if (!casc_i && run_q == CASC_RUN_W'(CASC_RD_HI)) gain = TOK_RD;
   end

   // No pulse on the line is longer than the read-token pulse
   p_rx_len_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      casc_i |-> run_q != CASC_RUN_W'(CASC_RD_HI));

endmodule

// File: rtl/casc_slice_store.sv
`timescale 1ns/1ps
module casc_slice_store
   import casc_fifo_pkg::*;
#(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    count
);

   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (WIDTH < 1) begin : g_bad_width
      $error("casc_slice_store: WIDTH must be at least 1");
   end
   if (DEPTH < CASC_MIN_DEPTH) begin : g_bad_depth
      $error("casc_slice_store: DEPTH below minimum pulse spacing");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wptr_q, rptr_q, wptr_nx, rptr_nx;
   logic [CW-1:0]    cnt_q;

   if (POW2) begin : g_wrap_free
      assign wptr_nx = wptr_q + 1'b1;
      assign rptr_nx = rptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign wptr_nx = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      assign rptr_nx = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push) mem[wptr_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wptr_q <= wptr_nx;
         if (pop)  rptr_q <= rptr_nx;
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   assign head  = mem[rptr_q];
   assign count = cnt_q;

   p_no_overflow_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CW'(DEPTH)) |-> !(push && !pop));
   p_no_underflow_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> !pop);

endmodule

// File: rtl/casc_fifo_slice.sv
`timescale 1ns/1ps
module casc_fifo_slice
   import casc_fifo_pkg::*;
#(
   parameter int unsigned WIDTH     = 9,
   parameter int unsigned DEPTH     = 8,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_head_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic             wr_ok,
   input  logic             rd_en,
   output logic             rd_vld,
   output logic [WIDTH-1:0] rd_data,
   input  logic             casc_i,
   output logic             casc_o
);

   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic             wr_tok_q, rd_tok_q, stale_q;
   logic [CW-1:0]    cnt;
   logic [WIDTH-1:0] head;
   logic             push, pop, fill, drain;
   casc_tok_e        gain, send;

   assign wr_ok  = wr_tok_q && !stale_q && (cnt != CW'(DEPTH));
   assign rd_vld = rd_tok_q && (cnt != '0);
   assign push   = wr_en && wr_ok;
   assign pop    = rd_en && rd_vld;
   // A block is complete when the owner reaches DEPTH words
   assign fill   = push && !pop && (cnt == CW'(DEPTH - 1));
   // The last word of a completed block leaves the slice
   assign drain  = pop && stale_q && (cnt == CW'(1));
   assign send   = fill ? TOK_WR : (drain ? TOK_RD : TOK_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_tok_q <= !strap_head_n;
         rd_tok_q <= !strap_head_n;
         stale_q  <= 1'b0;
      end else begin
         wr_tok_q <= (wr_tok_q && !fill)  || (gain == TOK_WR);
         rd_tok_q <= (rd_tok_q && !drain) || (gain == TOK_RD);
         stale_q  <= (stale_q && !drain)  || fill;
      end
   end

   casc_slice_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .wdata (wr_data),
      .head  (head),
      .count (cnt)
   );

   casc_link_tx i_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .send   (send),
      .casc_o (casc_o)
   );

   casc_link_rx i_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .casc_i (casc_i),
      .gain   (gain)
   );

   if (ZERO_IDLE) begin : g_out_masked
      assign rd_data = rd_vld ? head : '0;
   end else begin : g_out_raw
      assign rd_data = head;
   end

   p_idle_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ok && !(rd_en && rd_vld)) |=> $stable(cnt));
   p_fill_drop_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      fill |=> !wr_ok);
   p_drain_drop_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      drain |=> !rd_vld);
   p_stale_gate_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (stale_q && !drain) |=> !wr_ok);

endmodule

// File: tb/test_casc_fifo_slice.sv
`timescale 1ns/1ps
module test_casc_fifo_slice;

   localparam int unsigned W = 8;
   localparam int unsigned D = 4;
   localparam int unsigned N = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic         wr_en = 1'b0;
   logic         rd_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [N-1:0] wr_ok, rd_vld, casc_o, casc_i;
   logic [W-1:0] rd_data [N];
   logic [W-1:0] ring_data;

   for (genvar k = 0; k < N; k++) begin : g_sl
      assign casc_i[k] = casc_o[(k + N - 1) % N];
      casc_fifo_slice #(.WIDTH(W), .DEPTH(D)) i_casc_fifo_slice (
         .clk          (clk),
         .rst_n        (rst_n),
         .strap_head_n (1'(k != 0)),
         .wr_en        (wr_en),
         .wr_data      (wr_data),
         .wr_ok        (wr_ok[k]),
         .rd_en        (rd_en),
         .rd_vld       (rd_vld[k]),
         .rd_data      (rd_data[k]),
         .casc_i       (casc_i[k]),
         .casc_o       (casc_o[k])
      );
   end

   always_comb begin
      ring_data = '0;
      for (int k = 0; k < N; k++) ring_data = ring_data | rd_data[k];
   end

   int n_chk = 0;
   int n_bad = 0;
   logic [W-1:0] q[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // One cycle: decide from current outputs, drive, advance past the edge
   task automatic step(input logic we, input logic [W-1:0] wd, input logic re);
      if (re && (|rd_vld)) begin
         if (q.size() == 0) chk("R10 read with empty model", 1, 0);
         else chk("R10 order", ring_data, q.pop_front());
      end
      if (we && (|wr_ok)) q.push_back(wd);
      wr_en   = we;
      wr_data = wd;
      rd_en   = re;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1 wr_ok", wr_ok, 3'b001);
      chk("R1 rd_vld", rd_vld, 3'b000);
      chk("R1 casc_o", casc_o, 3'b000);
   endtask

   task automatic t_fill_pass();
      for (int i = 1; i <= 3; i++) begin
         step(1'b1, W'(i), 1'b0);
         chk("R2 owner keeps wr_ok", wr_ok, 3'b001);
      end
      step(1'b1, 8'd4, 1'b0);
      chk("R3 wr_ok after fill", wr_ok, 3'b000);
      chk("R3 casc_o high", casc_o, 3'b001);
      chk("R9 show-ahead head", ring_data, 8'd1);
      chk("R9 idle slice zero", rd_data[1], 8'd0);
      step(1'b1, 8'hEE, 1'b0);
      chk("R3 casc_o one cycle", casc_o, 3'b000);
      chk("R5 not yet owned", wr_ok, 3'b000);
      step(1'b1, 8'hEE, 1'b0);
      chk("R5 receiver owns write", wr_ok, 3'b010);
      chk("R2 others ignored writes", rd_vld, 3'b001);
   endtask

   task automatic t_read_pass();
      step(1'b1, 8'd5, 1'b0);
      step(1'b1, 8'd6, 1'b0);
      chk("R6 no read token yet", rd_vld, 3'b001);
      for (int i = 0; i < 3; i++) begin
         step(1'b0, '0, 1'b1);
         chk("R4 still draining", rd_vld, 3'b001);
      end
      step(1'b0, '0, 1'b1);
      chk("R4 rd_vld drop", rd_vld, 3'b000);
      chk("R4 casc_o first", casc_o, 3'b001);
      step(1'b0, '0, 1'b0);
      chk("R4 casc_o second", casc_o, 3'b001);
      step(1'b0, '0, 1'b0);
      chk("R4 casc_o low", casc_o, 3'b000);
      chk("R6 not yet owned", rd_vld, 3'b000);
      step(1'b0, '0, 1'b0);
      chk("R6 receiver owns read", rd_vld, 3'b010);
      chk("R6 head word", ring_data, 8'd5);
   endtask

   task automatic t_hold_empty();
      step(1'b0, '0, 1'b1);
      step(1'b0, '0, 1'b1);
      chk("R8 empty no rd_vld", rd_vld, 3'b000);
      chk("R8 wr_ok kept", wr_ok, 3'b010);
      for (int i = 0; i < 4; i++) begin
         step(1'b0, '0, 1'b0);
         chk("R8 no pulse", casc_o, 3'b000);
         chk("R8 token kept", rd_vld, 3'b000);
      end
      step(1'b1, 8'd7, 1'b0);
      chk("R8 rd_vld back", rd_vld, 3'b010);
      chk("R8 new word", ring_data, 8'd7);
      step(1'b1, 8'd8, 1'b1);
      chk("R11 rd_vld", rd_vld, 3'b010);
      chk("R11 head", ring_data, 8'd8);
      chk("R11 wr_ok", wr_ok, 3'b010);
   endtask

   task automatic t_stale();
      logic [W-1:0] v = 8'd9;
      for (int i = 0; i < 40 && v <= 8'd19; i++) begin
         if (|wr_ok) begin
            step(1'b1, v, 1'b0);
            v++;
         end else begin
            step(1'b1, v, 1'b0);
         end
      end
      chk("R7 all words taken", v, 8'd20);
      for (int i = 0; i < 4; i++) begin
         step(1'b1, 8'hEE, 1'b0);
         chk("R7 full ring", wr_ok, 3'b000);
      end
      chk("R7 oldest head", ring_data, 8'd8);
      for (int i = 0; i < 3; i++) begin
         step(1'b1, 8'hEE, 1'b1);
         chk("R7 stale blocks writes", wr_ok, 3'b000);
      end
      step(1'b1, 8'hEE, 1'b1);
      chk("R7 wr_ok after block drained", wr_ok, 3'b010);
      chk("R4 read pulse from S1", casc_o, 3'b010);
      chk("R4 S1 rd_vld drop", rd_vld, 3'b000);
   endtask

   task automatic t_mix();
      logic [15:0] lfsr = 16'hACE1;
      logic [W-1:0] v = 8'h40;
      for (int i = 0; i < 800; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (|wr_ok && (lfsr[0] | lfsr[3])) begin
            step(1'b1, v, lfsr[1]);
            v++;
         end else begin
            step(lfsr[0] | lfsr[3], v, lfsr[1]);
         end
         if (!$onehot0(wr_ok)) chk("R2 single writer", wr_ok, 0);
         if (!$onehot0(rd_vld)) chk("R9 single driver", rd_vld, 0);
      end
      for (int i = 0; i < 300 && q.size() != 0; i++) step(1'b0, '0, 1'b1);
      chk("R10 all words read", q.size(), 0);
      repeat (4) step(1'b0, '0, 1'b1);
      chk("R10 ring empty", rd_vld, 3'b000);
   endtask

   initial begin
      t_reset();
      t_fill_pass();
      t_read_pass();
      t_hold_empty();
      t_stale();
      t_mix();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule